// File: doc/BRIEF.md
# Byte-Stream Register Access Engine

This block sits behind one or more host links and turns a plain stream of bytes into reads and writes of an internal bank of eight-bit registers. Every command opens with a control byte, then a start address, then a 16-bit count sent low byte first. A write command is followed by exactly that many payload bytes, which are stored into the bank. A read command ends after the count, and the engine then streams the requested register contents back.

Each input byte carries the tag of the host port it came from. The tag seen on the control byte stays with the command, and every response byte goes out with that tag, so the surrounding fabric can steer the reply back to the port that asked. The physical links are outside the block. Both byte interfaces use a valid/ready handshake.

The controller is a six-state machine. `S_HDR` accepts the control byte and moves to `S_ADDR`. `S_ADDR` takes the start address and moves to `S_LEN_LO`. `S_LEN_LO` takes the low count byte and moves to `S_LEN_HI`. `S_LEN_HI` takes the high count byte and then goes back to `S_HDR` when the count is zero or the command is a no-op. Otherwise it goes to `S_WDATA` for a write or to `S_RDATA` for a read. `S_WDATA` returns to `S_HDR` after the last payload byte is accepted. `S_RDATA` returns to `S_HDR` after the last response byte is taken.

Top module: `regacc_engine`

## Requirements
- R1: In the control byte, bit 0 requests a write, bit 1 requests a read and bit 2 enables address stepping. A byte with both bit 0 and bit 1 set is executed as a write.
- R2: Bits 7:4 and bit 3 of the control byte have no effect on the command.
- R3: After the control byte, the engine takes one address byte and then a two-byte count, low byte first, so the count is {fourth byte, third byte}.
- R4: A write stores exactly count payload bytes into the bank. The byte that follows them is decoded as a new control byte.
- R5: With stepping on, the register address rises by one after each data byte and wraps from 255 to 0. With stepping off, every data byte uses the start address.
- R6: A read presents count bytes on `out_data`, each equal to the addressed register. While `out_ready` is low, `out_valid`, `out_data` and `out_id` hold steady.
- R7: Every response byte carries on `out_id` the `in_id` value seen with its command's control byte.
- R8: A control byte with neither bit 0 nor bit 1 set still consumes its address and count bytes, then produces no output and changes no register.
- R9: A count of zero ends the command right after the fourth byte. No payload is taken and no response is sent.
- R10: `in_ready` is low for the whole time a response is being sent. The next control byte is accepted only after the last response byte has been taken.
- R11: After reset, `in_ready` is high, `out_valid` is low and all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Engine can accept an input byte |
| in_data | input | 8 | Input byte |
| in_id | input | ID_W | Source port tag of the input byte |
| out_valid | output | 1 | Response byte present |
| out_ready | input | 1 | Receiver takes the response byte |
| out_data | output | 8 | Response byte |
| out_id | output | ID_W | Destination port tag of the response byte |

## Verification
The input side and the output side can both be busy in the same cycle. This happens when the next control byte is already waiting on the input while a response is still streaming out. The bench holds the input valid throughout a read and checks, on every response cycle, that `in_ready` stays low. Receiver backpressure is switched on and off during long reads. The bench then checks that the waiting command is taken only after the final response byte, and that every byte read back matches a register model built only from the earlier write commands.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        S_HDR,
        S_ADDR,
        S_LEN_LO,
        S_LEN_HI,
        S_WDATA,
        S_RDATA
    } state_e;

    typedef enum logic [1:0] {
        OP_NOP,
        OP_WR,
        OP_RD
    } op_e;
endpackage

// File: rtl/regacc_hdr_decode.sv
module regacc_hdr_decode
    import regacc_pkg::*;
(
    input  logic [2:0] ctl_bits,
    output op_e        op,
    output logic       step_en
);
    // write has priority over read
    always_comb begin
        if (ctl_bits[0])      op = OP_WR;
        else if (ctl_bits[1]) op = OP_RD;
        else                  op = OP_NOP;
        step_en = ctl_bits[2];
    end
endmodule

// File: rtl/regacc_regbank.sv
module regacc_regbank #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we) begin
            regs[addr] <= wdata;
        end
    end

    assign rdata = regs[addr];
endmodule

// File: rtl/regacc_ctrl.sv
module regacc_ctrl
    import regacc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ID_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic [ID_W-1:0]   in_id,
    input  logic              out_ready,
    input  op_e               hdr_op,
    input  logic              hdr_step,
    output logic              in_ready,
    output logic              out_valid,
    output logic [ID_W-1:0]   out_id,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr
);
    state_e              state, state_nx;
    op_e                 cmd_op;
    logic                cmd_step;
    logic [ID_W-1:0]     cmd_id;
    logic [ADDR_W-1:0]   cur_addr;
    logic [BYTE_W-1:0]   len_lo;
    logic [LEN_W-1:0]    remain;
    logic                take, give, last;
    logic [LEN_W-1:0]    len_full;

    assign take     = in_valid && in_ready;
    assign give     = out_valid && out_ready;
    assign last     = (remain == LEN_W'(1));
    assign len_full = {in_data, len_lo};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HDR;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_HDR:    if (take) state_nx = S_ADDR;
            S_ADDR:   if (take) state_nx = S_LEN_LO;
            S_LEN_LO: if (take) state_nx = S_LEN_HI;
            S_LEN_HI: if (take) begin
                if (len_full == '0 || cmd_op == OP_NOP) state_nx = S_HDR;
                else if (cmd_op == OP_WR)               state_nx = S_WDATA;
                else                                    state_nx = S_RDATA;
            end
            S_WDATA:  if (take && last) state_nx = S_HDR;
            S_RDATA:  if (give && last) state_nx = S_HDR;
            default:  state_nx = S_HDR;
        endcase
    end

    // command context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_op   <= OP_NOP;
            cmd_step <= 1'b0;
            cmd_id   <= '0;
            cur_addr <= '0;
            len_lo   <= '0;
            remain   <= '0;
        end else begin
            unique case (state)
                S_HDR: if (take) begin
                    cmd_op   <= hdr_op;
                    cmd_step <= hdr_step;
                    cmd_id   <= in_id;
                end
                S_ADDR:   if (take) cur_addr <= in_data[ADDR_W-1:0];
                S_LEN_LO: if (take) len_lo <= in_data;
                S_LEN_HI: if (take) remain <= len_full;
                S_WDATA: if (take) begin
                    cur_addr <= cur_addr + ADDR_W'(cmd_step);
                    remain   <= remain - LEN_W'(1);
                end
                S_RDATA: if (give) begin
                    cur_addr <= cur_addr + ADDR_W'(cmd_step);
                    remain   <= remain - LEN_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = (state != S_RDATA);
        out_valid = (state == S_RDATA);
        out_id    = cmd_id;
        mem_we    = (state == S_WDATA) && in_valid;
        mem_addr  = cur_addr;
    end
endmodule

// File: rtl/regacc_engine.sv
module regacc_engine
    import regacc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ID_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic [ID_W-1:0]   in_id,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic [ID_W-1:0]   out_id
);
    op_e               hdr_op;
    logic              hdr_step;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;

    regacc_hdr_decode u_dec (
        .ctl_bits (in_data[2:0]),
        .op       (hdr_op),
        .step_en  (hdr_step)
    );

    regacc_ctrl #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_id     (in_id),
        .out_ready (out_ready),
        .hdr_op    (hdr_op),
        .hdr_step  (hdr_step),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_id    (out_id),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr)
    );

    regacc_regbank #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (in_data),
        .rdata (out_data)
    );
endmodule

// File: rtl/regacc_engine_chk.sv
module regacc_engine_chk #(
    parameter int ID_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [7:0]      out_data,
    input logic [ID_W-1:0] out_id
);
    // R10: no input accepted while a response byte is pending
    p_stall_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R6: response held under backpressure
    p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_id)));

    // R7: tag constant across one response burst
    p_id_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(out_id));

    // R3: a response begins only right after an input byte was taken
    p_resp_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R11: idle state accepts input, no response
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_ready && !out_valid));
endmodule

bind regacc_engine regacc_engine_chk #(.ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_id    (out_id)
);

// File: tb/regacc_engine_tb.sv
module regacc_engine_tb;
    localparam int ID_W = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [7:0]      in_data = '0;
    logic [ID_W-1:0] in_id = '0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [7:0]      out_data;
    logic [ID_W-1:0] out_id;

    int vecs = 0;
    int bad  = 0;
    logic [7:0] model [256];

    always #5 clk = ~clk;

    regacc_engine #(.ADDR_W(8), .ID_W(ID_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_id     (in_id),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_id    (out_id)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the byte is taken
    task automatic send_byte(input logic [7:0] b, input logic [ID_W-1:0] id);
        in_valid = 1'b1;
        in_data  = b;
        in_id    = id;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] hdr, input logic [7:0] addr,
                            input int len, input logic [ID_W-1:0] id);
        send_byte(hdr, id);
        send_byte(addr, id);
        send_byte(len[7:0], id);   // R3: low byte first
        send_byte(len[15:8], id);
    endtask

    task automatic wr_cmd(input logic [7:0] hdr, input logic [7:0] addr, input int len,
                          input logic [ID_W-1:0] id, input int seed, input int stride);
        logic [7:0] a;
        send_cmd(hdr, addr, len, id);
        a = addr;
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'(seed + i * stride);
            send_byte(b, id);
            model[a] = b;
            if (hdr[2]) a = a + 8'd1;
        end
    endtask

    task automatic rd_cmd(input logic [7:0] hdr, input logic [7:0] addr, input int len,
                          input logic [ID_W-1:0] id, input bit bp, input bit hold_next);
        logic [7:0] a;
        int n;
        int cyc;
        send_cmd(hdr, addr, len, id);
        if (hold_next) begin
            in_valid = 1'b1;
            in_data  = 8'h00;
            in_id    = id;
        end
        a = addr;
        n = 0;
        cyc = 0;
        while (n < len) begin
            out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
            cyc++;
            if (out_valid) begin
                if (in_ready) chk(1'b0, "R10 in_ready during response", 1, 0);
                if (out_ready) begin
                    chk(out_data == model[a], "R6 read data", out_data, model[a]);
                    chk(out_id == id, "R7 response tag", out_id, id);
                    n++;
                    if (hdr[2]) a = a + 8'd1;
                end
            end
            @(negedge clk);
        end
        out_ready = 1'b1;
        chk(!out_valid && in_ready, "R10 done after last byte", out_valid, 0);
        if (hold_next) begin
            @(negedge clk);   // pending control byte (no-op) taken now
            in_valid = 1'b0;
            send_byte(8'h00, id);
            send_byte(8'h00, id);
            send_byte(8'h00, id);
        end
    endtask

    task automatic quiet(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            chk(!out_valid && in_ready, tag, out_valid, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid, "R11 reset ports", {in_ready, out_valid}, 2);
        rd_cmd(8'h06, 8'h00, 256, 2'd0, 1'b0, 1'b0);           // R11 all zero

        // full sweep write with stepping, then read with backpressure (R4, R5, R6)
        wr_cmd(8'h05, 8'h00, 256, 2'd1, 3, 7);
        rd_cmd(8'h06, 8'h00, 256, 2'd2, 1'b1, 1'b0);

        // R5 stepping off: last payload byte wins, read repeats one address
        wr_cmd(8'h01, 8'h10, 5, 2'd3, 8'hA1, 1);
        chk(model[8'h10] == 8'hA5, "R5 model", model[8'h10], 8'hA5);
        rd_cmd(8'h02, 8'h10, 4, 2'd1, 1'b0, 1'b0);
        rd_cmd(8'h06, 8'h0F, 3, 2'd1, 1'b0, 1'b0);

        // R5 wrap from 255 to 0
        wr_cmd(8'h05, 8'hFE, 4, 2'd0, 8'h50, 3);
        rd_cmd(8'h06, 8'hFD, 6, 2'd2, 1'b1, 1'b0);

        // R1 write+read executes as write, no response
        wr_cmd(8'h07, 8'h40, 3, 2'd2, 8'h11, 17);
        quiet(3, "R1 no response for write+read");
        rd_cmd(8'h06, 8'h40, 3, 2'd3, 1'b0, 1'b0);

        // R2 high bits and bit 3 ignored
        wr_cmd(8'hFD, 8'h60, 2, 2'd1, 8'hC3, 1);
        rd_cmd(8'hAE, 8'h60, 2, 2'd0, 1'b0, 1'b0);

        // R8 no-op
        send_cmd(8'hFC, 8'h70, 5, 2'd1);
        quiet(4, "R8 no-op silent");
        rd_cmd(8'h06, 8'h70, 5, 2'd1, 1'b0, 1'b0);

        // R9 zero count write: next byte is a control byte
        wr_cmd(8'h05, 8'h80, 0, 2'd2, 8'hEE, 1);
        rd_cmd(8'h06, 8'h80, 1, 2'd2, 1'b0, 1'b0);
        send_cmd(8'h06, 8'h80, 0, 2'd3);
        quiet(3, "R9 zero count read silent");

        // R3 high count byte: 258-byte read wraps around the bank
        rd_cmd(8'h06, 8'h80, 258, 2'd3, 1'b1, 1'b0);

        // R10 next command waiting during response
        rd_cmd(8'h06, 8'h20, 8, 2'd2, 1'b1, 1'b1);
        rd_cmd(8'h06, 8'h20, 2, 2'd1, 1'b0, 1'b0);

        // R4 exact payload count followed by a command
        wr_cmd(8'h05, 8'h90, 3, 2'd0, 8'h01, 2);
        rd_cmd(8'h06, 8'h8F, 5, 2'd0, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule